// File: doc/BRIEF.md
# Dual-Mode FIFO Controller with Retransmit

This block is a single-clock FIFO that owns its storage array, its read and write pointers and its output register. It runs in one of two timing modes, chosen when master reset is applied. In standard mode each word must be fetched by a read request. In fall-through mode the oldest stored word is moved to the output by itself, and a read request only consumes it. The two status pins keep the same polarity in both modes: `out_flag` high means data can be read, and `in_flag` high means a write will be taken. In standard mode they are the inverted empty and full conditions. In fall-through mode they are output-ready and input-ready.

Two reset paths exist. Master reset also captures the timing mode. A shared active-low input, `prst_rt_n`, does one of two things depending on `rt_mode`. With `rt_mode` low it flushes the FIFO and keeps the mode. With `rt_mode` high it rewinds the read side, so that everything written since the last flush is read again. This replay is intended for streams of at most DEPTH words.

The data interface uses plain enables, not a valid/ready handshake. `in_flag` and `out_flag` act as the ready and valid indications. A write made while `in_flag` is low, or a read made while `out_flag` is low, is dropped, and the source must hold the word and try again.

Top module: `twomode_fifo`

## Requirements
- R1: The block samples `std_sel` on every clock edge at which `mrst_n` is low. A value of 1 selects standard mode and a value of 0 selects fall-through mode. Changing `std_sel` at any other time has no effect.
- R2: One edge with `mrst_n` low empties the FIFO, sets `rd_data` to all zeros, drives `out_flag` low and drives `in_flag` high.
- R3: In standard mode, a word that is written does not reach `rd_data` until a read is made. A read that is accepted at an edge places the oldest word on `rd_data` after that edge. `out_flag` is high while at least one word is stored, and `in_flag` is low while DEPTH words are stored. Without an accepted read, `rd_data` holds its value.
- R4: In fall-through mode, a word written into an empty FIFO appears on `rd_data` one edge after the edge that wrote it, with `out_flag` high, and no read is needed.
- R5: In fall-through mode, a read made while `out_flag` is high consumes the presented word. At that same edge, `rd_data` changes to the next word, or `out_flag` falls if no word remains. `in_flag` is low while DEPTH words are held, counting the presented word. Without a read, the presented word and `out_flag` stay unchanged.
- R6: A write needs `wr_en` high. A read needs both `rd_en` and `rd_cs` high. Without these, a transfer does not happen.
- R7: A write made while `in_flag` is low is ignored. In standard mode, a read made while `out_flag` is low is ignored and `rd_data` keeps its value.
- R8: With `prst_rt_n` low and `rt_mode` low, one edge empties the FIFO, clears `rd_data` to zero, drops `out_flag` and keeps the timing mode.
- R9: With `prst_rt_n` low and `rt_mode` high, reads restart from the first word written since the last flush, and the write side keeps its place. In standard mode `rd_data` holds its value. In fall-through mode `out_flag` drops for one edge, and then the first word falls through again.
- R10: Master reset takes priority over `prst_rt_n`. No write or read takes effect at an edge where either reset input is low.
- R11: Words leave in the order they were written, for any mix of writes, reads and flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action happens on its rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| std_sel | input | 1 | Timing mode select sampled during master reset (1 = standard) |
| prst_rt_n | input | 1 | Shared flush / rewind request, active low |
| rt_mode | input | 1 | Chooses rewind (1) or flush (0) for `prst_rt_n` |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data |
| in_flag | output | 1 | High while a write would be accepted |
| rd_en | input | 1 | Read enable |
| rd_cs | input | 1 | Read-side select; must be high together with `rd_en` |
| rd_data | output | DATA_W | Output register |
| out_flag | output | 1 | High while a read would be accepted |

## Verification
Directed sequences fill the FIFO to DEPTH and drain it to empty in each mode. They also push extra writes against a full FIFO and reads against an empty one, which separates back-pressure that is honoured from pointers that wrap when they should not. Rewinds are issued after partial draining in both modes, and are followed by further writes. This separates a read-pointer-only reset from a full flush, and also checks whether the fall-through output is refilled correctly. A change of `std_sel` followed by a flush, and resets applied together with enables, show whether the mode is stored and whether reset takes priority. Long random runs in each mode, with occasional flushes, compare every output against an order-keeping reference.

// File: rtl/twf_pkg.sv
`timescale 1ns/1ps
package twf_pkg;
  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_STD  = 1'b1
  } twf_mode_e;
endpackage

// File: rtl/twf_ctrl.sv
`timescale 1ns/1ps
// Reset decode and timing-mode register.
module twf_ctrl
  import twf_pkg::*;
(
  input  logic      clk,
  input  logic      mrst_n,
  input  logic      std_sel,
  input  logic      prst_rt_n,
  input  logic      rt_mode,
  output twf_mode_e mode,
  output logic      clr,   // master or partial: wipe pointers and output
  output logic      rew,   // rewind read side only
  output logic      busy   // any reset action this edge
);
  twf_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= twf_mode_e'(std_sel);
  end

  assign mode = mode_q;
  assign clr  = !mrst_n || (!prst_rt_n && !rt_mode);
  assign rew  = mrst_n && !prst_rt_n && rt_mode;
  assign busy = !mrst_n || !prst_rt_n;
endmodule

// File: rtl/twf_ptrs.sv
`timescale 1ns/1ps
// Wrap-extended pointers; level is derived, so a rewind needs no separate count update.
module twf_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          rew,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [AW:0]   level
);
  logic [AW:0] wr_p, rd_p;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_p <= '0;
      rd_p <= '0;
    end else if (rew) begin
      rd_p <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
    end
  end

  assign wr_idx = wr_p[AW-1:0];
  assign rd_idx = rd_p[AW-1:0];
  assign level  = wr_p - rd_p;
endmodule

// File: rtl/twf_mem.sv
`timescale 1ns/1ps
// Storage array: synchronous write, combinational read.
module twf_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/twf_outstage.sv
`timescale 1ns/1ps
// Output register, fall-through valid bit, and mode-dependent flags.
module twf_outstage
  import twf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  twf_mode_e         mode,
  input  logic              clr,
  input  logic              rew,
  input  logic              busy,
  input  logic              rd_req,
  input  logic [AW:0]       level,
  input  logic [DATA_W-1:0] mem_q,
  output logic              pop,
  output logic [DATA_W-1:0] q,
  output logic              out_flag,
  output logic              in_flag
);
  logic              ov;
  logic              has;
  logic              fall;
  logic [AW+1:0]     total;

  assign fall  = (mode == MODE_FALL);
  assign has   = (level != '0);
  assign total = {1'b0, level} + (AW+2)'(ov);

  always_comb begin
    if (busy)      pop = 1'b0;
    else if (fall) pop = has && (!ov || rd_req);
    else           pop = has && rd_req;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      q  <= '0;
      ov <= 1'b0;
    end else if (rew) begin
      if (fall) ov <= 1'b0;
    end else if (pop) begin
      q  <= mem_q;
      ov <= fall;
    end else if (fall && rd_req && ov) begin
      ov <= 1'b0;
    end
  end

  always_comb begin
    if (fall) begin
      out_flag = ov;
      in_flag  = total < (AW+2)'(DEPTH);
    end else begin
      out_flag = has;
      in_flag  = level != (AW+1)'(DEPTH);
    end
  end
endmodule

// File: rtl/twomode_fifo.sv
`timescale 1ns/1ps
module twomode_fifo
  import twf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              std_sel,
  input  logic              prst_rt_n,
  input  logic              rt_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_flag,
  input  logic              rd_en,
  input  logic              rd_cs,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_flag
);
  localparam int AW = $clog2(DEPTH);

  twf_mode_e         mode;
  logic              clr, rew, busy;
  logic              push, pop, rd_req;
  logic [AW-1:0]     wr_idx, rd_idx;
  logic [AW:0]       level;
  logic [DATA_W-1:0] mem_q;
  logic              mode_is_std;

  assign rd_req      = rd_en && rd_cs;
  assign push        = !busy && wr_en && in_flag;
  assign mode_is_std = (mode == MODE_STD);

  twf_ctrl u_ctrl (
    .clk(clk), .mrst_n(mrst_n), .std_sel(std_sel), .prst_rt_n(prst_rt_n),
    .rt_mode(rt_mode), .mode(mode), .clr(clr), .rew(rew), .busy(busy)
  );

  twf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .clr(clr), .rew(rew), .push(push), .pop(pop),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .level(level)
  );

  twf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_idx), .rdata(mem_q)
  );

  twf_outstage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out (
    .clk(clk), .mode(mode), .clr(clr), .rew(rew), .busy(busy),
    .rd_req(rd_req), .level(level), .mem_q(mem_q), .pop(pop),
    .q(rd_data), .out_flag(out_flag), .in_flag(in_flag)
  );
endmodule

// File: rtl/twf_checker.sv
`timescale 1ns/1ps
module twf_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              mrst_n,
  input logic              prst_rt_n,
  input logic              rt_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_cs,
  input logic              in_flag,
  input logic              out_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic              mode_std
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_mode_kept_R1: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_std));

  assert_master_clears_R2: assert property (@(posedge clk) disable iff (!armed)
    !mrst_n |=> (!out_flag && in_flag && rd_data == '0));

  assert_std_hold_R3: assert property (@(posedge clk) disable iff (!mrst_n || !prst_rt_n)
    (mode_std && !(rd_en && rd_cs)) |=> $stable(rd_data));

  assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_rt_n)
    (!mode_std && out_flag && !(rd_en && rd_cs)) |=> (out_flag && $stable(rd_data)));

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_rt_n)
    (!in_flag && wr_en && !(rd_en && rd_cs)) |=> !in_flag);

  assert_empty_blocks_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_rt_n)
    (mode_std && !out_flag && !wr_en) |=> (!out_flag && $stable(rd_data)));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_rt_n && !rt_mode) |=> (!out_flag && in_flag && rd_data == '0));

  assert_rewind_std_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_rt_n && rt_mode && mode_std) |=> $stable(rd_data));

  assert_rewind_fall_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_rt_n && rt_mode && !mode_std) |=> !out_flag);
endmodule

bind twomode_fifo twf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_rt_n(prst_rt_n), .rt_mode(rt_mode),
  .wr_en(wr_en), .rd_en(rd_en), .rd_cs(rd_cs), .in_flag(in_flag),
  .out_flag(out_flag), .rd_data(rd_data), .mode_std(mode_is_std)
);

// File: tb/twomode_fifo_bench.sv
`timescale 1ns/1ps
module twomode_fifo_bench;
  localparam int W = 16;
  localparam int D = 8;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, std_sel = 1'b1, prst_rt_n = 1'b1, rt_mode = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rd_cs = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic in_flag, out_flag;

  always #10 clk = ~clk;

  twomode_fifo #(.DATA_W(W), .DEPTH(D)) u_twomode_fifo (
    .clk(clk), .mrst_n(mrst_n), .std_sel(std_sel), .prst_rt_n(prst_rt_n),
    .rt_mode(rt_mode), .wr_en(wr_en), .wr_data(wr_data), .in_flag(in_flag),
    .rd_en(rd_en), .rd_cs(rd_cs), .rd_data(rd_data), .out_flag(out_flag)
  );

  // Reference model built from the requirements.
  int m_wr = 0, m_rd = 0;
  bit m_std = 1'b1, m_ov = 1'b0;
  logic [W-1:0] m_q = '0;
  logic [W-1:0] hist [int];
  int n_chk = 0, n_fail = 0;
  string tag = "R2";

  always @(posedge clk) begin
    int  cnt;
    bit  rq, space;
    if (!mrst_n) begin
      m_std = std_sel; m_wr = 0; m_rd = 0; m_ov = 1'b0; m_q = '0;
    end else if (!prst_rt_n) begin
      if (!rt_mode) begin m_wr = 0; m_rd = 0; m_ov = 1'b0; m_q = '0; end
      else begin m_rd = 0; if (!m_std) m_ov = 1'b0; end
    end else begin
      cnt   = m_wr - m_rd;
      rq    = rd_en && rd_cs;
      space = m_std ? (cnt < D) : ((cnt + int'(m_ov)) < D);
      if (m_std) begin
        if (rq && cnt > 0) begin m_q = hist[m_rd]; m_rd++; end
      end else begin
        if (cnt > 0 && (!m_ov || rq)) begin m_q = hist[m_rd]; m_rd++; m_ov = 1'b1; end
        else if (rq && m_ov) m_ov = 1'b0;
      end
      if (wr_en && space) begin hist[m_wr] = wr_data; m_wr++; end
    end
  end

  function automatic int exp_out();
    return m_std ? int'((m_wr - m_rd) != 0) : int'(m_ov);
  endfunction
  function automatic int exp_in();
    return m_std ? int'((m_wr - m_rd) != D) : int'((m_wr - m_rd + int'(m_ov)) < D);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(tag, "rd_data", int'(rd_data), int'(m_q));
    check(tag, "out_flag", int'(out_flag), exp_out());
    check(tag, "in_flag", int'(in_flag), exp_in());
  endtask

  task automatic push(input logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask
  task automatic pop();
    rd_en = 1'b1; rd_cs = 1'b1; tick(); rd_en = 1'b0;
  endtask
  task automatic mreset(input bit sel);
    mrst_n = 1'b0; std_sel = sel; repeat (4) tick(); mrst_n = 1'b1;
  endtask
  task automatic preset(input bit rtm);
    prst_rt_n = 1'b0; rt_mode = rtm; tick(); prst_rt_n = 1'b1; rt_mode = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R2 master reset into standard mode
    tag = "R2"; mreset(1'b1);
    check("R2", "rd_data", int'(rd_data), 0);
    check("R2", "out_flag", int'(out_flag), 0);
    check("R2", "in_flag", int'(in_flag), 1);

    // R3 / R6 standard read path
    tag = "R3"; push(16'h1111);
    check("R3", "rd_data before read", int'(rd_data), 0);
    check("R3", "out_flag", int'(out_flag), 1);
    tag = "R6"; rd_en = 1'b1; rd_cs = 1'b0; tick(); rd_en = 1'b0; rd_cs = 1'b1;
    check("R6", "rd_data without select", int'(rd_data), 0);
    tag = "R3"; pop();
    check("R3", "rd_data after read", int'(rd_data), 16'h1111);
    check("R3", "out_flag empty", int'(out_flag), 0);

    // R3 full, R7 overflow and underflow, R11 order
    for (int i = 0; i < D; i++) push(16'h2000 + 16'(i));
    check("R3", "in_flag full", int'(in_flag), 0);
    tag = "R7"; push(16'hDEAD);
    tag = "R11";
    for (int i = 0; i < D; i++) begin
      pop();
      check("R11", "order std", int'(rd_data), 16'h2000 + i);
    end
    tag = "R7"; pop();
    check("R7", "read on empty", int'(rd_data), 16'h2000 + D - 1);

    // R10 reset priority, enables ignored
    tag = "R10"; wr_en = 1'b1; wr_data = 16'h7777; mrst_n = 1'b0; prst_rt_n = 1'b0;
    tick(); mrst_n = 1'b1; prst_rt_n = 1'b1; wr_en = 1'b0; tick();
    check("R10", "out_flag after reset", int'(out_flag), 0);

    // R1 / R8: mode kept across flush
    tag = "R8"; push(16'h3333); std_sel = 1'b0; preset(1'b0);
    check("R8", "out_flag", int'(out_flag), 0);
    check("R8", "rd_data", int'(rd_data), 0);
    tag = "R1"; push(16'h4444); tick();
    check("R1", "no fall-through", int'(rd_data), 0);
    pop(); check("R1", "std read", int'(rd_data), 16'h4444);

    // R9 rewind in standard mode
    tag = "R9"; preset(1'b0);
    push(16'hA0); push(16'hA1); push(16'hA2); pop(); pop();
    preset(1'b1);
    check("R9", "std rd_data held", int'(rd_data), 16'hA1);
    check("R9", "std out_flag", int'(out_flag), 1);
    pop(); check("R9", "replay first", int'(rd_data), 16'hA0);
    push(16'hA3); pop(); pop(); pop();
    check("R9", "write side kept", int'(rd_data), 16'hA3);

    // Fall-through mode
    tag = "R2"; mreset(1'b0);
    check("R2", "fall out_flag", int'(out_flag), 0);
    tag = "R4"; push(16'h5555);
    check("R4", "not yet shown", int'(out_flag), 0);
    tick();
    check("R4", "fall rd_data", int'(rd_data), 16'h5555);
    check("R4", "fall out_flag", int'(out_flag), 1);
    tag = "R6"; rd_en = 1'b1; rd_cs = 1'b0; tick(); rd_en = 1'b0; rd_cs = 1'b1;
    check("R6", "fall held", int'(out_flag), 1);
    tag = "R5"; pop();
    check("R5", "drained", int'(out_flag), 0);

    for (int i = 0; i < D; i++) push(16'h6000 + 16'(i));
    tick();
    check("R5", "in_flag full", int'(in_flag), 0);
    tag = "R7"; push(16'hBEEF);
    tag = "R5";
    for (int i = 1; i < D; i++) begin
      pop();
      check("R5", "next word same edge", int'(rd_data), 16'h6000 + i);
    end
    pop(); check("R5", "empty after last", int'(out_flag), 0);

    // R9 rewind in fall-through mode
    tag = "R9"; preset(1'b0);
    push(16'hC0); push(16'hC1); push(16'hC2); tick(); pop();
    check("R9", "fall before rewind", int'(rd_data), 16'hC1);
    preset(1'b1);
    check("R9", "fall out_flag drop", int'(out_flag), 0);
    tick();
    check("R9", "fall replay", int'(rd_data), 16'hC0);

    // Random phases in each mode
    for (int m = 0; m < 2; m++) begin
      tag = "R11"; mreset(m[0]);
      for (int c = 0; c < 2500; c++) begin
        wr_en = ($urandom % 100) < 55;
        wr_data = W'($urandom);
        rd_en = ($urandom % 100) < 50;
        rd_cs = ($urandom % 100) < 90;
        prst_rt_n = !(($urandom % 100) < 1);
        rt_mode = 1'b0;
        tick();
      end
      wr_en = 1'b0; rd_en = 1'b0; prst_rt_n = 1'b1;
    end
    tick();
    summary();
  end
endmodule